// File: doc/BRIEF.md
# Port Power-State Controller with Energy-Detect Sleep

This block decides, cycle by cycle, whether the datapath of one Ethernet PHY port is powered, whether it may transmit, and when it must be put through a local reset. Software can force the port down with a power-down control bit. Alternatively, an energy-detect mode lets the port fall asleep on its own whenever the line is quiet, and wake again as soon as line energy returns. The management interface and the energy-sensing front end sit outside this block and are never switched off by it.

Every return to service goes through a fixed-length reset window. During that window the datapath is powered, transmission is still held off, and a reset request goes to the PHY core. There are three ways back: software releases power-down, energy is sensed during sleep, or the energy-detect mode is switched off during sleep. A wake caused by energy also raises a sticky interrupt flag, which stays set until software clears it. The packets that trigger a wake may be lost, and nothing here buffers them. This block holds no configuration registers, so entering or leaving a low-power state leaves configuration untouched.

The raw line-energy indication is asynchronous. It passes through a two-stage synchroniser before the state machine uses it or software sees it. Reset is asserted asynchronously and released through its own synchroniser.

Top module: `port_power_mgr`

## Requirements
- R1: `energy_status` equals `line_energy` delayed by two clock edges (two-flop synchroniser), and it is the only path by which line energy reaches the state machine.
- R2: On the clock edge that samples `sw_pdown` high, the port enters software power-down: `dp_power_en`=0 and `tx_inhibit`=1 from then on, for as long as `sw_pdown` stays high.
- R3: When `sw_pdown` is sampled low in software power-down, the port enters a reset window of exactly RST_LEN cycles. In that window `phy_reset_req`=1, `dp_power_en`=1 and `tx_inhibit`=1. After it the port is active: `phy_reset_req`=0 and `tx_inhibit`=0.
- R4: When the port is active, `ed_enable`=1, `sw_pdown`=0 and `energy_status`=0, the next edge puts the port to sleep. While asleep: `dp_power_en`=0, `tx_inhibit`=1 and `phy_reset_req`=0.
- R5: When the port is asleep and `energy_status`=1, the next edge starts the same RST_LEN-cycle reset window as R3 and sets `wake_irq`.
- R6: `wake_irq` is sticky. It clears only on an edge with `irq_clr`=1 and no wake. A wake on the same edge as `irq_clr` leaves it set. Only an energy wake sets it.
- R7: With `ed_enable`=0 the port never enters sleep. Clearing `ed_enable` while asleep starts the reset window without setting `wake_irq`.
- R8: Software power-down has priority in every state, including sleep and the reset window. While `sw_pdown`=1, line energy neither wakes the port nor sets `wake_irq`.
- R9: During reset the outputs are `dp_power_en`=1, `tx_inhibit`=0, `energy_status`=0, `wake_irq`=0 and `phy_reset_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_pdown | input | 1 | Software power-down request, active high |
| ed_enable | input | 1 | Energy-detect sleep mode enable, active high |
| line_energy | input | 1 | Asynchronous line-energy indication from the analog front end |
| irq_clr | input | 1 | Software clear of the wake interrupt flag |
| dp_power_en | output | 1 | Datapath power enable |
| tx_inhibit | output | 1 | Blocks transmission while asleep, powered down or in reset |
| energy_status | output | 1 | Synchronised energy-present status |
| wake_irq | output | 1 | Sticky energy-wake interrupt flag |
| phy_reset_req | output | 1 | Reset request to the PHY core, high for RST_LEN cycles on each return to service |

## Verification
The bench puts a wake and an interrupt clear on the same edge. A design that lets the clear win would lose the interrupt. It holds software power-down while line energy toggles, so a design without the right priority would wake or raise the flag behind software's back. It counts the reset window after each kind of exit, so an off-by-one timer shows up as a window of RST_LEN±1 cycles. It also clears `ed_enable` during sleep. A design that ignored this would leave the port dark, and one that treated it as an energy wake would raise a false interrupt.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_SWDOWN = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_WAKE   = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/ppm_sync_chain.sv
// Multi-stage synchroniser, used both for the reset release and for the
// asynchronous line-energy indication.
module ppm_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("ppm_sync_chain needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ppm_rst_timer.sv
// Counts the cycles spent in the reset window; done marks its last cycle.
module ppm_rst_timer #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int            CW   = $clog2(RST_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_LEN - 1);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    if (!run)              cnt_nxt = '0;
    else if (cnt == LAST)  cnt_nxt = cnt;
    else                   cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/ppm_irq_flag.sv
// Sticky interrupt source flag: set has priority over clear.
module ppm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic en;
  assign en = set | clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flag <= 1'b0;
    else if (en) flag <= set;
  end
endmodule

// File: rtl/ppm_fsm.sv
// Power-state sequencer. Software power-down overrides every other cause.
module ppm_fsm
  import ppm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_pdown,
  input  logic ed_enable,
  input  logic energy,
  input  logic win_done,
  output logic win_run,
  output logic wake_evt,
  output logic pwr_en,
  output logic tx_off,
  output logic rst_req
);
  pwr_state_t state, state_nxt;

  always_comb begin
    state_nxt = state;
    wake_evt  = 1'b0;
    if (sw_pdown) begin
      state_nxt = PS_SWDOWN;
    end else begin
      unique case (state)
        PS_ACTIVE: if (ed_enable && !energy) state_nxt = PS_SLEEP;
        PS_SWDOWN: state_nxt = PS_WAKE;
        PS_SLEEP: begin
          if (!ed_enable) begin
            state_nxt = PS_WAKE;
          end else if (energy) begin
            state_nxt = PS_WAKE;
            wake_evt  = 1'b1;
          end
        end
        PS_WAKE:   if (win_done) state_nxt = PS_ACTIVE;
        default:   state_nxt = PS_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_ACTIVE;
    else        state <= state_nxt;
  end

  assign win_run = (state == PS_WAKE);
  assign pwr_en  = (state == PS_ACTIVE) || (state == PS_WAKE);
  assign tx_off  = (state != PS_ACTIVE);
  assign rst_req = (state == PS_WAKE);
endmodule

// File: rtl/port_power_mgr.sv
module port_power_mgr #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_LEN     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_pdown,
  input  logic ed_enable,
  input  logic line_energy,
  input  logic irq_clr,
  output logic dp_power_en,
  output logic tx_inhibit,
  output logic energy_status,
  output logic wake_irq,
  output logic phy_reset_req
);
  logic rst_n_core;
  logic energy_s;
  logic win_run, win_done, wake_evt;

  ppm_sync_chain #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_core)
  );

  ppm_sync_chain #(.STAGES(SYNC_STAGES)) i_energy_sync (
    .clk(clk), .rst_n(rst_n_core), .d(line_energy), .q(energy_s)
  );

  ppm_rst_timer #(.RST_LEN(RST_LEN)) i_timer (
    .clk(clk), .rst_n(rst_n_core), .run(win_run), .done(win_done)
  );

  ppm_fsm i_fsm (
    .clk(clk), .rst_n(rst_n_core),
    .sw_pdown(sw_pdown), .ed_enable(ed_enable), .energy(energy_s),
    .win_done(win_done), .win_run(win_run), .wake_evt(wake_evt),
    .pwr_en(dp_power_en), .tx_off(tx_inhibit), .rst_req(phy_reset_req)
  );

  ppm_irq_flag i_irq (
    .clk(clk), .rst_n(rst_n_core), .set(wake_evt), .clr(irq_clr), .flag(wake_irq)
  );

  assign energy_status = energy_s;
endmodule

// File: rtl/ppm_checker.sv
module ppm_checker (
  input logic clk,
  input logic rst_n,
  input logic sw_pdown,
  input logic ed_enable,
  input logic line_energy,
  input logic irq_clr,
  input logic dp_power_en,
  input logic tx_inhibit,
  input logic energy_status,
  input logic wake_irq,
  input logic phy_reset_req
);
  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  p_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd5) |-> (energy_status == $past(line_energy, 2)));

  p_swdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pdown |=> (!dp_power_en && tx_inhibit));

  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phy_reset_req |-> (dp_power_en && tx_inhibit));

  p_sleep_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_power_en |-> (tx_inhibit && !phy_reset_req));

  p_irq_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> phy_reset_req);

  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !irq_clr) |=> wake_irq);

  p_no_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ed_enable && !sw_pdown && dp_power_en) |=> dp_power_en);

  p_no_irq_in_swdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pdown && !wake_irq) |=> !wake_irq);
endmodule

bind port_power_mgr ppm_checker i_ppm_checker (.*);

// File: tb/test_port_power_mgr.sv
module test_port_power_mgr;
  localparam int RST_LEN = 4;
  localparam int ST_ACT = 0, ST_SW = 1, ST_SLP = 2, ST_WAKE = 3;

  logic clk = 1'b0;
  logic rst_n, sw_pdown, ed_enable, line_energy, irq_clr;
  logic dp_power_en, tx_inhibit, energy_status, wake_irq, phy_reset_req;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  port_power_mgr #(.SYNC_STAGES(2), .RST_LEN(RST_LEN)) i_port_power_mgr (
    .clk(clk), .rst_n(rst_n), .sw_pdown(sw_pdown), .ed_enable(ed_enable),
    .line_energy(line_energy), .irq_clr(irq_clr), .dp_power_en(dp_power_en),
    .tx_inhibit(tx_inhibit), .energy_status(energy_status),
    .wake_irq(wake_irq), .phy_reset_req(phy_reset_req)
  );

  // Expected-value model built from the requirements. The design releases
  // reset two cycles later; the bench keeps all inputs low across that gap.
  logic m_s1, m_s2, m_irq;
  int   m_st, m_win;

  function automatic int next_st(int st, logic sw, logic ed, logic e, int win);
    if (sw) return ST_SW;
    case (st)
      ST_ACT:  return (ed && !e) ? ST_SLP : ST_ACT;
      ST_SW:   return ST_WAKE;
      ST_SLP:  return (!ed || e) ? ST_WAKE : ST_SLP;
      default: return (win == RST_LEN - 1) ? ST_ACT : ST_WAKE;
    endcase
  endfunction

  function automatic logic exp_pwr(int st); return st == ST_ACT || st == ST_WAKE; endfunction
  function automatic logic exp_tx(int st);  return st != ST_ACT; endfunction
  function automatic logic exp_rr(int st);  return st == ST_WAKE; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_irq <= 1'b0; m_st <= ST_ACT; m_win <= 0;
    end else begin
      m_s1 <= line_energy;
      m_s2 <= m_s1;
      m_st <= next_st(m_st, sw_pdown, ed_enable, m_s2, m_win);
      m_win <= (m_st == ST_WAKE && next_st(m_st, sw_pdown, ed_enable, m_s2, m_win) == ST_WAKE)
               ? m_win + 1 : 0;
      if (m_st == ST_SLP && !sw_pdown && ed_enable && m_s2) m_irq <= 1'b1;
      else if (irq_clr)                                     m_irq <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    string t;
    case (m_st)
      ST_SW:   t = "R2";
      ST_WAKE: t = "R3";
      ST_SLP:  t = "R4";
      default: t = "R7";
    endcase
    chk(energy_status == m_s2, "R1 energy_status", energy_status, m_s2);
    chk(dp_power_en == exp_pwr(m_st), {t, " dp_power_en"}, dp_power_en, exp_pwr(m_st));
    chk(tx_inhibit == exp_tx(m_st), {t, " tx_inhibit"}, tx_inhibit, exp_tx(m_st));
    chk(phy_reset_req == exp_rr(m_st), {t, " phy_reset_req"}, phy_reset_req, exp_rr(m_st));
    chk(wake_irq == m_irq, "R6 wake_irq", wake_irq, m_irq);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst_n = 1'b0; sw_pdown = 1'b0; ed_enable = 1'b0; line_energy = 1'b0; irq_clr = 1'b0;
    void'($urandom(32'h0051_3ad7));
    repeat (3) @(negedge clk);
    // R9 reset values
    chk(dp_power_en == 1'b1 && tx_inhibit == 1'b0 && energy_status == 1'b0 &&
        wake_irq == 1'b0 && phy_reset_req == 1'b0, "R9 reset outputs",
        {dp_power_en, tx_inhibit, energy_status, wake_irq, phy_reset_req}, 5'b10000);
    rst_n = 1'b1;
    repeat (4) step();

    // R2, R8: software power-down holds against line energy
    sw_pdown = 1'b1; ed_enable = 1'b1;
    step();
    chk(dp_power_en == 1'b0, "R2 power off", dp_power_en, 0);
    for (int i = 0; i < 8; i++) begin
      line_energy = ~line_energy;
      step();
      chk(dp_power_en == 1'b0 && wake_irq == 1'b0, "R8 energy ignored",
          {dp_power_en, wake_irq}, 0);
    end
    // R3: release gives an RST_LEN reset window, then active
    ed_enable = 1'b0; line_energy = 1'b1; sw_pdown = 1'b0;
    for (int i = 0; i < RST_LEN; i++) begin
      step();
      chk(phy_reset_req && dp_power_en && tx_inhibit, "R3 window",
          {phy_reset_req, dp_power_en, tx_inhibit}, 3'b111);
    end
    step();
    chk(!phy_reset_req && !tx_inhibit, "R3 window end", {phy_reset_req, tx_inhibit}, 0);

    // R4: energy-detect sleep
    ed_enable = 1'b1; line_energy = 1'b0;
    repeat (3) step();
    chk(!dp_power_en && tx_inhibit && !phy_reset_req, "R4 asleep",
        {dp_power_en, tx_inhibit, phy_reset_req}, 3'b010);
    // R5 with R6 priority: wake coincides with a held clear
    irq_clr = 1'b1; line_energy = 1'b1;
    repeat (3) step();
    chk(wake_irq == 1'b1, "R5 R6 wake sets flag despite clear", wake_irq, 1);
    chk(phy_reset_req == 1'b1, "R5 wake window", phy_reset_req, 1);
    step();
    chk(wake_irq == 1'b0, "R6 clear after wake", wake_irq, 0);
    irq_clr = 1'b0;
    repeat (RST_LEN + 1) step();

    // R7: disabling energy detect while asleep wakes without interrupt
    line_energy = 1'b0;
    repeat (4) step();
    chk(dp_power_en == 1'b0, "R7 precondition asleep", dp_power_en, 0);
    ed_enable = 1'b0;
    step();
    chk(phy_reset_req == 1'b1 && wake_irq == 1'b0, "R7 wake no irq",
        {phy_reset_req, wake_irq}, 2'b10);
    repeat (RST_LEN + 6) step();
    chk(dp_power_en == 1'b1, "R7 stays powered", dp_power_en, 1);

    // R8: power-down during reset window takes over
    ed_enable = 1'b1; line_energy = 1'b0;
    repeat (4) step();
    line_energy = 1'b1;
    repeat (3) step();
    sw_pdown = 1'b1;
    step();
    chk(dp_power_en == 1'b0 && phy_reset_req == 1'b0, "R8 override window",
        {dp_power_en, phy_reset_req}, 0);
    sw_pdown = 1'b0;

    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(5) == 0)  line_energy = ~line_energy;
      if ($urandom_range(39) == 0) sw_pdown = ~sw_pdown;
      if ($urandom_range(29) == 0) ed_enable = ~ed_enable;
      irq_clr = ($urandom_range(7) == 0);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule